// File: doc/BRIEF.md
# Memory Bank Switch and Copy Engine

This controller sits beside a processor core that addresses eight banks of 64K sixteen-bit words. It owns the three-bit selector naming the bank the core currently works in. It carries out one bank command per request. The command is packed into a single sixteen-bit operand and holds four fields: a block index, a source bank, a destination bank and a target bank. One command can copy a 512-word block from the source bank to the destination bank, move the selector to the target bank, do both, or do neither.

Copying a block onto the bank it came from is skipped, and so is a switch to the bank already selected. The number of cycles a command takes depends only on the actions that actually run. The core raises `op_valid` with the operand while `busy` is low. `busy` then stays high for the whole cost of the command. `done` marks the final cycle, and `cycles_used` afterwards reports the cost. Copies stream through a port eight words wide: in each cycle one aligned group is read from the source bank and the same group is written to the destination bank.

Top module: `bank_xfer_ctrl`

## Requirements
- R1: After reset `cur_bank` is 0, `busy`, `done` and `mem_wr_en` are low, and `cycles_used` is 0.
- R2: The operand is decoded as follows: bits 15..9 are the block index, bits 8..6 the source bank, bits 5..3 the destination bank and bits 2..0 the target bank.
- R3: When source and destination differ, the 512 words at addresses block*512 through block*512+511 of the source bank are copied to the same addresses of the destination bank. Words outside that range are left untouched.
- R4: When source equals destination, no write strobe occurs and no memory word changes.
- R5: When the target differs from `cur_bank`, `cur_bank` takes the target value once the command ends. Otherwise `cur_bank` is unchanged.
- R6: A command keeps `busy` high for exactly 1 + 64·copy + 8·switch cycles, where copy and switch are 1 when that action happens. After the command, `cycles_used` holds this number.
- R7: A copy issues exactly 64 read/write cycles. Each cycle reads and writes the same eight-word group. Lane k of the 128-bit buses (bits 16k+15..16k) is the word at group address + k. The group address starts at block*512 and rises by 8 each cycle.
- R8: When a command both copies and switches, `cur_bank` keeps its old value for every cycle `busy` is high, and it changes only after the copy has finished.
- R9: `done` is high for exactly one cycle per command, and that cycle is the last cycle in which `busy` is high.
- R10: A request presented while `busy` is high is ignored: it has no effect on memory, `cur_bank`, the cost, or on whether a later command starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Command request, accepted when busy is low |
| op_word | input | 16 | Packed bank command operand |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Final cycle of the command in progress |
| cycles_used | output | 7 | Cost in cycles of the last completed command |
| cur_bank | output | 3 | Currently selected bank |
| mem_rd_en | output | 1 | Group read strobe |
| mem_rd_bank | output | 3 | Bank read from |
| mem_rd_addr | output | 16 | Address of lane 0 of the group read |
| mem_rd_data | input | 128 | Group read data, valid in the same cycle |
| mem_wr_en | output | 1 | Group write strobe |
| mem_wr_bank | output | 3 | Bank written to |
| mem_wr_addr | output | 16 | Address of lane 0 of the group written |
| mem_wr_data | output | 128 | Group write data |

## Verification
The assertions check on every cycle that the counted busy time matches the decoded cost at `done`, and that `busy` falls right after `done`. They also check that the selector moves only directly after a `done`, that writes never target the bank being read, that the group address advances by the lane count, and that a request arriving mid-command leaves the latched operand alone. Only the bench's scenarios can show that the copied words actually land in the right bank and at the right addresses, and that neighbouring words stay unchanged. The scenarios also show that skipped actions cost nothing and that an ignored request does not start a second command.

// File: rtl/bank_xfer_pkg.sv
package bank_xfer_pkg;

    localparam int BANK_W  = 3;
    localparam int BLOCK_W = 7;
    localparam int ADDR_W  = 16;
    localparam int WORD_W  = 16;

    typedef logic [BANK_W-1:0] bank_t;

    // Field order is fixed by the operand encoding (MSB first).
    typedef struct packed {
        logic [BLOCK_W-1:0] block;
        bank_t              src;
        bank_t              dst;
        bank_t              tgt;
    } bank_op_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_BASE,
        PH_COPY,
        PH_SWITCH
    } phase_e;

endpackage

// File: rtl/bank_op_decode.sv
module bank_op_decode
    import bank_xfer_pkg::*;
#(
    parameter int GROUPS      = 64,
    parameter int SWITCH_COST = 8,
    parameter int COST_W      = 7
) (
    input  bank_op_t                op_i,
    input  bank_t                   cur_bank_i,
    output logic                    copy_o,
    output logic                    switch_o,
    output logic [ADDR_W-1:0]       base_o,
    output logic [COST_W-1:0]       cost_o
);

    localparam int SHIFT = ADDR_W - BLOCK_W;

    always_comb begin
        copy_o   = (op_i.src != op_i.dst);
        switch_o = (op_i.tgt != cur_bank_i);
        base_o   = {op_i.block, {SHIFT{1'b0}}};
        cost_o   = COST_W'(1)
                 + (copy_o   ? COST_W'(GROUPS)      : '0)
                 + (switch_o ? COST_W'(SWITCH_COST) : '0);
    end

endmodule

// File: rtl/bank_copy_walker.sv
module bank_copy_walker
    import bank_xfer_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int GROUPS = 64,
    localparam int IDX_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int LANE_SH = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              active_o,
    output logic              last_o,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        logic              active;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] base;
    } walk_t;

    walk_t w_d, w_q;

    always_comb begin
        active_o = w_q.active;
        last_o   = w_q.active && (w_q.idx == IDX_W'(GROUPS - 1));
        addr_o   = w_q.base + (ADDR_W'(w_q.idx) << LANE_SH);

        w_d = w_q;
        if (start_i) begin
            w_d.active = 1'b1;
            w_d.idx    = '0;
            w_d.base   = base_i;
        end else if (w_q.active) begin
            w_d.idx = w_q.idx + IDX_W'(1);
            if (last_o) begin
                w_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    // R7: consecutive groups sit LANES words apart
    assert_group_stride_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !last_o) |=> (active_o && (addr_o == $past(addr_o) + ADDR_W'(LANES))));

endmodule

// File: rtl/bank_xfer_ctrl.sv
module bank_xfer_ctrl
    import bank_xfer_pkg::*;
#(
    parameter int LANES       = 8,
    parameter int SWITCH_COST = 8,
    localparam int BLOCK_WORDS = 1 << (ADDR_W - BLOCK_W),
    localparam int GROUPS      = BLOCK_WORDS / LANES,
    localparam int COST_W      = $clog2(GROUPS + SWITCH_COST + 2),
    localparam int SW_W        = $clog2(SWITCH_COST + 1),
    localparam int BUS_W       = LANES * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [WORD_W-1:0] op_word,
    output logic              busy,
    output logic              done,
    output logic [COST_W-1:0] cycles_used,
    output logic [BANK_W-1:0] cur_bank,
    output logic              mem_rd_en,
    output logic [BANK_W-1:0] mem_rd_bank,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [BUS_W-1:0]  mem_rd_data,
    output logic              mem_wr_en,
    output logic [BANK_W-1:0] mem_wr_bank,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [BUS_W-1:0]  mem_wr_data
);

    typedef struct packed {
        phase_e            phase;
        bank_op_t          op;
        bank_t             cur_bank;
        logic [SW_W-1:0]   sw_cnt;
        logic [COST_W-1:0] elapsed;
        logic [COST_W-1:0] last_cost;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic              do_copy, do_switch;
    logic [ADDR_W-1:0] base_addr;
    logic [COST_W-1:0] cost_dec;
    logic              walk_start, walk_active, walk_last;
    logic [ADDR_W-1:0] walk_addr;
    logic              finish;

    bank_op_decode #(
        .GROUPS      (GROUPS),
        .SWITCH_COST (SWITCH_COST),
        .COST_W      (COST_W)
    ) u_decode (
        .op_i       (s_q.op),
        .cur_bank_i (s_q.cur_bank),
        .copy_o     (do_copy),
        .switch_o   (do_switch),
        .base_o     (base_addr),
        .cost_o     (cost_dec)
    );

    bank_copy_walker #(
        .LANES  (LANES),
        .GROUPS (GROUPS)
    ) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (walk_start),
        .base_i   (base_addr),
        .active_o (walk_active),
        .last_o   (walk_last),
        .addr_o   (walk_addr)
    );

    always_comb begin
        s_d        = s_q;
        walk_start = 1'b0;
        finish     = 1'b0;

        unique case (s_q.phase)
            PH_IDLE: begin
                if (op_valid) begin
                    s_d.phase   = PH_BASE;
                    s_d.op      = bank_op_t'(op_word);
                    s_d.elapsed = COST_W'(1);
                end
            end
            PH_BASE: begin
                s_d.elapsed = s_q.elapsed + COST_W'(1);
                if (do_copy) begin
                    walk_start = 1'b1;
                    s_d.phase  = PH_COPY;
                end else if (do_switch) begin
                    s_d.phase  = PH_SWITCH;
                    s_d.sw_cnt = SW_W'(SWITCH_COST - 1);
                end else begin
                    finish = 1'b1;
                end
            end
            PH_COPY: begin
                s_d.elapsed = s_q.elapsed + COST_W'(1);
                if (walk_last) begin
                    if (do_switch) begin
                        s_d.phase  = PH_SWITCH;
                        s_d.sw_cnt = SW_W'(SWITCH_COST - 1);
                    end else begin
                        finish = 1'b1;
                    end
                end
            end
            PH_SWITCH: begin
                s_d.elapsed = s_q.elapsed + COST_W'(1);
                if (s_q.sw_cnt == '0) begin
                    finish = 1'b1;
                end else begin
                    s_d.sw_cnt = s_q.sw_cnt - SW_W'(1);
                end
            end
        endcase

        if (finish) begin
            s_d.phase     = PH_IDLE;
            s_d.last_cost = s_q.elapsed;
            if (do_switch) begin
                s_d.cur_bank = s_q.op.tgt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        busy        = (s_q.phase != PH_IDLE);
        done        = finish;
        cycles_used = s_q.last_cost;
        cur_bank    = s_q.cur_bank;
        mem_rd_en   = walk_active;
        mem_rd_bank = s_q.op.src;
        mem_rd_addr = walk_addr;
        mem_wr_en   = walk_active;
        mem_wr_bank = s_q.op.dst;
        mem_wr_addr = walk_addr;
        mem_wr_data = mem_rd_data;
    end

    // R6: counted busy time equals the decoded cost at completion
    assert_cost_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (s_q.elapsed == cost_dec));

    // R9: done is the final busy cycle
    assert_done_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8: the selector moves only right after completion
    assert_bank_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.cur_bank) |-> $past(done));

    // R4: never write into the bank being read
    assert_no_self_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wr_bank != mem_rd_bank));

    // R7: memory traffic only in the copy phase
    assert_copy_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (s_q.phase == PH_COPY));

    // R10: a request during a command leaves the held operand alone
    assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_valid) |=> $stable(s_q.op));

endmodule

// File: tb/bank_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module bank_xfer_ctrl_tb;

    localparam int LANES = 8;
    localparam int BUS_W = LANES * 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_valid = 1'b0;
    logic [15:0]      op_word = '0;
    logic             busy, done;
    logic [6:0]       cycles_used;
    logic [2:0]       cur_bank;
    logic             mem_rd_en, mem_wr_en;
    logic [2:0]       mem_rd_bank, mem_wr_bank;
    logic [15:0]      mem_rd_addr, mem_wr_addr;
    logic [BUS_W-1:0] mem_rd_data, mem_wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    int wr_events = 0;
    logic [2:0] model_bank = '0;

    logic [15:0] amem [int];
    logic [15:0] emem [int];

    always #10 clk = ~clk;

    bank_xfer_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
        .busy(busy), .done(done), .cycles_used(cycles_used), .cur_bank(cur_bank),
        .mem_rd_en(mem_rd_en), .mem_rd_bank(mem_rd_bank), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_bank(mem_wr_bank),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    function automatic int key_of(logic [2:0] b, logic [15:0] a);
        return int'({13'd0, b, a});
    endfunction

    function automatic logic [15:0] pattern(logic [2:0] b, logic [15:0] a);
        return 16'(a * 16'd40503) ^ {b, 13'h1357};
    endfunction

    function automatic logic [15:0] act_read(logic [2:0] b, logic [15:0] a);
        int k = key_of(b, a);
        return amem.exists(k) ? amem[k] : pattern(b, a);
    endfunction

    function automatic logic [15:0] exp_read(logic [2:0] b, logic [15:0] a);
        int k = key_of(b, a);
        return emem.exists(k) ? emem[k] : pattern(b, a);
    endfunction

    function automatic int exp_cost(bit cp, bit sw);
        return 1 + (cp ? 64 : 0) + (sw ? 8 : 0);
    endfunction

    // behavioural memory: same-cycle group read, write at the clock edge
    always @(mem_rd_bank or mem_rd_addr or wr_events) begin
        for (int l = 0; l < LANES; l++)
            mem_rd_data[l*16 +: 16] = act_read(mem_rd_bank, mem_rd_addr + 16'(l));
    end

    always @(posedge clk) begin
        if (mem_wr_en) begin
            for (int l = 0; l < LANES; l++)
                amem[key_of(mem_wr_bank, mem_wr_addr + 16'(l))] = mem_wr_data[l*16 +: 16];
            wr_events++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic run_op(input logic [15:0] w, input bit poke);
        logic [6:0]  blk = w[15:9];
        logic [2:0]  src = w[8:6];
        logic [2:0]  dst = w[5:3];
        logic [2:0]  tgt = w[2:0];
        logic [15:0] base = {blk, 9'd0};
        bit cp = (src != dst);
        bit sw = (tgt != model_bank);
        int cost = exp_cost(cp, sw);
        logic [2:0] start_bank = model_bank;
        int n = 0, done_cnt = 0, done_at = 0, writes = 0, mism = 0;
        bit early = 0, bad_addr = 0;

        if (cp)
            for (int i = 0; i < 512; i++)
                emem[key_of(dst, base + 16'(i))] = exp_read(src, base + 16'(i));

        @(negedge clk);
        op_valid = 1'b1;
        op_word  = w;
        @(negedge clk);
        op_valid = 1'b0;
        while (busy && n < 300) begin
            n++;
            if (done) begin done_cnt++; done_at = n; end
            if (cur_bank != start_bank) early = 1;
            if (mem_wr_en) begin
                if (mem_wr_addr != base + 16'(8 * writes) || mem_rd_addr != mem_wr_addr
                    || mem_wr_bank != dst || mem_rd_bank != src) bad_addr = 1;
                writes++;
            end
            if (poke && n == 3) begin
                op_valid = 1'b1;
                op_word  = ~w;
            end
            @(negedge clk);
            op_valid = 1'b0;
        end

        check(n == cost, "R6 busy length", n, cost);
        check(int'(cycles_used) == cost, "R6 cycles_used", int'(cycles_used), cost);
        check(done_cnt == 1 && done_at == n, "R9 done pulse at", done_at, n);
        check(!early, "R8 bank held during busy", int'(early), 0);
        check(cur_bank == (sw ? tgt : start_bank), "R5 R2 cur_bank", int'(cur_bank),
              int'(sw ? tgt : start_bank));
        check(writes == (cp ? 64 : 0) && !bad_addr, "R7 R4 write cycles", writes, cp ? 64 : 0);
        for (int a = -8; a < 520; a++) begin
            logic [15:0] ad = base + 16'(a);
            if (act_read(dst, ad) != exp_read(dst, ad)) mism++;
            if (act_read(src, ad) != exp_read(src, ad)) mism++;
        end
        check(mism == 0, cp ? "R3 copied block" : "R4 memory untouched", mism, 0);
        check(amem.num() == emem.num(), "R3 R4 stray writes", amem.num(), emem.num());
        if (poke) begin
            @(negedge clk);
            check(!busy, "R10 ignored request started nothing", int'(busy), 0);
        end
        model_bank = sw ? tgt : start_bank;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        int unused;
        unused = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && mem_wr_en == 0, "R1 idle after reset", int'(busy), 0);
        check(cur_bank == 0 && cycles_used == 0, "R1 bank and cost after reset",
              int'(cur_bank), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(16'h0000, 0);                              // nothing: cost 1
        run_op({7'd0, 3'd0, 3'd0, 3'd5}, 0);              // switch only
        run_op({7'd3, 3'd1, 3'd2, 3'd5}, 0);              // copy only
        run_op({7'd127, 3'd2, 3'd6, 3'd0}, 0);            // both, top block
        run_op({7'd10, 3'd4, 3'd4, 3'd7}, 0);             // same-bank copy, switch
        run_op({7'd127, 3'd6, 3'd1, 3'd7}, 1);            // copy, request while busy
        run_op({7'd0, 3'd1, 3'd0, 3'd7}, 1);              // copy block 0 back
        for (int i = 0; i < 30; i++) begin
            logic [15:0] w = 16'($urandom);
            if (i % 4 == 0) w[5:3] = w[8:6];
            run_op(w, ($urandom % 2) == 1);
        end
        summary();
    end

endmodule